// File: doc/BRIEF.md
# Variable-Length Instruction Prefetch Queue

This block sits between instruction memory and the decode stage of a stack-machine pipeline. Memory returns one aligned 4-byte word per response. The block collects these bytes in an 8-byte queue and finds where each instruction ends. An instruction is one opcode byte followed by zero to four operand bytes. When every byte of the instruction at the head of the queue has arrived, the block offers the whole instruction to decode together with its length. If the instruction is not yet complete, decode sees an empty slot (a bubble).

The opcode sets the instruction length through a small lookup. Opcodes outside the supported set are issued as one-byte instructions and carry a flag, so that the pipeline can trap on them.

The block asks memory for the next word whenever enough room is guaranteed for it. When the pipeline takes a jump, the block does four things:
- It empties the queue.
- It ignores every word it has already requested.
- It restarts fetching at the word that holds the target.
- It drops the bytes of that first word that come before the target.

Memory must answer requests in order, with a latency of at least one cycle. After reset the block stays idle until the first jump supplies a start address.

Top module: `bytecode_prefetch_queue`

## Requirements
- R1: After reset, `fetch_req` and `inst_valid` stay low until the first cycle in which `jump_valid` is high.
- R2: The number of queued bytes never exceeds 8, counting bytes still travelling in live requested words. A word is requested only if the queue plus all live outstanding words plus the new word fit in 8 bytes.
- R3: The first request after a jump uses the target address with its two low bits cleared. Each later request uses the previous request address plus 4.
- R4: `inst_valid` is high exactly when the queue holds at least as many bytes as the head opcode's length and `jump_valid` is low. `inst_bytes` carries the opcode in bits 7:0 and operand k in bits 8k+7:8k. Bytes beyond the length read as zero. A handshake (`inst_valid` and `inst_ready` both high) removes that many bytes.
- R5: At most two live words are outstanding. `fetch_req` is never high with two live words outstanding.
- R6: In a cycle with `jump_valid` high, the queue is emptied and the response arriving in that cycle is dropped. All responses to requests made before that cycle are also dropped. The next instruction issued starts at the jump target.
- R7: Opcode lengths are 1 byte for 0x00–0x3F, 2 bytes for 0x40–0x5F, 3 bytes for 0x60–0x7F, 4 bytes for 0x80–0x8F and 5 bytes for 0x90–0x9F.
- R8: Opcodes 0xA0–0xFF are issued with length 1 and with `inst_unknown` high. Known opcodes have `inst_unknown` low.
- R9: Memory words hold the byte at the lowest address in bits 7:0. After a jump to an unaligned target, the first live word drops its leading `target[1:0]` bytes, so the first instruction issued begins at the target byte.
- R10: While `inst_valid` is high and `inst_ready` is low, the same instruction stays offered in the next cycle unless a jump intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | output | 1 | Request for one word at `fetch_addr`; memory takes every request |
| fetch_addr | output | 32 | Word-aligned request address |
| mem_valid | input | 1 | A response word is present (responses in request order) |
| mem_data | input | 32 | Response word, lowest address in bits 7:0 |
| jump_valid | input | 1 | Taken jump: flush and restart |
| jump_target | input | 32 | Byte address of the jump target |
| inst_ready | input | 1 | Decode accepts the offered instruction |
| inst_valid | output | 1 | A complete instruction is offered |
| inst_bytes | output | 40 | Opcode and operand bytes, unused bytes zero |
| inst_len | output | 3 | Instruction length in bytes, 1 to 5 |
| inst_unknown | output | 1 | Opcode outside the supported set |

## Verification
A wrong byte count or a misplaced byte shows up at the ports in one of three ways, all in the very cycle the error takes effect. A handshake may carry bytes that differ from the memory stream at the expected program counter. `inst_valid` may come up one cycle early or late relative to the bytes delivered so far. Or a request may appear while the live outstanding words leave no room.

A stale word that is not dropped after a jump corrupts the first instruction issued at the target. A wrong skip count on an unaligned jump has the same effect, and so does a wrong fetch pointer, which also shows directly as a request address that breaks the plus-4 sequence. The reference model tracks occupancy from the responses and handshakes it sees. Because of this, any mismatch in count or drop bookkeeping is caught on the next cycle, not at the end of the run.

// File: rtl/bpq_pkg.sv
// Shared constants and the opcode length lookup for the prefetch queue.
// Assumes a one-byte opcode and instructions of at most MAX_INSN bytes.
package bpq_pkg;
    localparam int MAX_INSN = 5;
    localparam int LEN_W    = 3;

    typedef struct packed {
        logic             known;
        logic [LEN_W-1:0] len;
    } oplen_t;

    // Map an opcode to its total instruction length; unsupported codes give length 1.
    function automatic oplen_t opcode_length(input logic [7:0] op);
        oplen_t r;
        r.known = 1'b1;
        if (op < 8'h40)      r.len = LEN_W'(1);
        else if (op < 8'h60) r.len = LEN_W'(2);
        else if (op < 8'h80) r.len = LEN_W'(3);
        else if (op < 8'h90) r.len = LEN_W'(4);
        else if (op < 8'hA0) r.len = LEN_W'(5);
        else begin
            r.known = 1'b0;
            r.len   = LEN_W'(1);
        end
        return r;
    endfunction
endpackage

// File: rtl/bpq_len_decode.sv
// Opcode length decoder: turns the head byte of the queue into an instruction
// length and an unknown-opcode flag. Purely combinational.
module bpq_len_decode
    import bpq_pkg::*;
(
    input  logic [7:0]       opcode,
    output logic [LEN_W-1:0] len,
    output logic             unknown
);
    oplen_t info;

    // Look up the length entry for the current opcode.
    always_comb begin
        info    = opcode_length(opcode);
        len     = info.len;
        unknown = ~info.known;
    end
endmodule

// File: rtl/bpq_byte_store.sv
// Byte queue of QBYTES entries, byte 0 is the oldest. In one cycle it can drop
// pop_len bytes from the head and append one word with push_skip leading bytes
// removed. flush empties it. Assumes the caller never pops more than it holds
// and never pushes past capacity.
module bpq_byte_store #(
    parameter int QBYTES = 8,
    parameter int WBYTES = 4,
    parameter int CW     = $clog2(QBYTES + 1),
    parameter int SW     = $clog2(WBYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic                    pop_en,
    input  logic [CW-1:0]           pop_len,
    input  logic                    push_en,
    input  logic [WBYTES-1:0][7:0]  push_word,
    input  logic [SW-1:0]           push_skip,
    output logic [QBYTES-1:0][7:0]  bytes_o,
    output logic [CW-1:0]           count_o
);
    localparam int QIW = (QBYTES > 1) ? $clog2(QBYTES) : 1;
    localparam int WIW = (WBYTES > 1) ? $clog2(WBYTES) : 1;

    logic [QBYTES-1:0][7:0] q_r, q_nxt;
    logic [CW-1:0]          cnt_r, cnt_nxt;

    // Compact the remaining bytes to the head and append the trimmed word.
    always_comb begin
        int keep;
        int incoming;
        int src;
        keep     = int'(cnt_r) - (pop_en ? int'(pop_len) : 0);
        incoming = push_en ? (WBYTES - int'(push_skip)) : 0;
        src      = 0;
        for (int i = 0; i < QBYTES; i++) begin
            q_nxt[i] = 8'h00;
            if (i < keep) begin
                src      = i + (int'(cnt_r) - keep);
                q_nxt[i] = q_r[QIW'(src)];
            end else if ((i - keep) < incoming) begin
                src      = i - keep + int'(push_skip);
                q_nxt[i] = push_word[WIW'(src)];
            end
        end
        cnt_nxt = flush ? '0 : CW'(keep + incoming);
    end

    // Register the queue contents and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r   <= '0;
            cnt_r <= '0;
        end else begin
            q_r   <= q_nxt;
            cnt_r <= cnt_nxt;
        end
    end

    assign bytes_o = q_r;
    assign count_o = cnt_r;
endmodule

// File: rtl/bpq_fetch_ctrl.sv
// Fetch controller: holds the fetch pointer and counts outstanding requests and
// how many of them are stale after a jump. It also decides when a new word
// fits. Assumes in-order responses, at least one cycle after the request, and
// a memory that takes every request.
module bpq_fetch_ctrl #(
    parameter int AW       = 32,
    parameter int QBYTES   = 8,
    parameter int WBYTES   = 4,
    parameter int MAX_PEND = 2,
    parameter int CW       = $clog2(QBYTES + 1),
    parameter int SW       = $clog2(WBYTES),
    parameter int PW       = $clog2(MAX_PEND + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          jump_valid,
    input  logic [AW-1:0] jump_target,
    input  logic          mem_valid,
    input  logic [CW-1:0] q_count,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    output logic          word_accept,
    output logic [SW-1:0] word_skip,
    output logic [PW-1:0] live_pend
);
    logic          active_r;
    logic [AW-1:0] ptr_r;
    logic [PW-1:0] pend_r, drop_r;
    logic [SW-1:0] skip_r;
    logic          skip_pend_r;
    logic          room;

    // Decide whether a word may be requested and whether a response is kept.
    always_comb begin
        live_pend   = pend_r - drop_r;
        room        = (int'(q_count) + WBYTES * int'(live_pend) + WBYTES) <= QBYTES;
        fetch_req   = active_r && !jump_valid && (int'(pend_r) < MAX_PEND) && room;
        word_accept = mem_valid && !jump_valid && (drop_r == '0);
        word_skip   = skip_pend_r ? skip_r : '0;
    end

    // Track the pointer, outstanding and stale counts, and the pending skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_r    <= 1'b0;
            ptr_r       <= '0;
            pend_r      <= '0;
            drop_r      <= '0;
            skip_r      <= '0;
            skip_pend_r <= 1'b0;
        end else begin
            pend_r <= pend_r + PW'(fetch_req) - PW'(mem_valid);
            if (jump_valid) begin
                active_r    <= 1'b1;
                ptr_r       <= {jump_target[AW-1:SW], SW'(0)};
                drop_r      <= pend_r - PW'(mem_valid);
                skip_r      <= jump_target[SW-1:0];
                skip_pend_r <= 1'b1;
            end else begin
                if (mem_valid && (drop_r != '0)) drop_r <= drop_r - PW'(1);
                if (fetch_req) ptr_r <= ptr_r + AW'(WBYTES);
                if (word_accept) skip_pend_r <= 1'b0;
            end
        end
    end

    assign fetch_addr = ptr_r;
endmodule

// File: rtl/bytecode_prefetch_queue.sv
// Top of the prefetch queue. It joins the fetch controller, the byte store and
// the length decoder, and offers one complete variable-length instruction per
// cycle to decode. Assumes memory answers requests in order, and that the
// first jump after reset supplies the start address.
module bytecode_prefetch_queue
    import bpq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int QBYTES   = 8,
    parameter int WBYTES   = 4,
    parameter int MAX_PEND = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic                  fetch_req,
    output logic [AW-1:0]         fetch_addr,
    input  logic                  mem_valid,
    input  logic [8*WBYTES-1:0]   mem_data,
    input  logic                  jump_valid,
    input  logic [AW-1:0]         jump_target,
    input  logic                  inst_ready,
    output logic                  inst_valid,
    output logic [8*MAX_INSN-1:0] inst_bytes,
    output logic [LEN_W-1:0]      inst_len,
    output logic                  inst_unknown
);
    localparam int CW = $clog2(QBYTES + 1);
    localparam int SW = $clog2(WBYTES);
    localparam int PW = $clog2(MAX_PEND + 1);

    logic [QBYTES-1:0][7:0] q_bytes;
    logic [CW-1:0]          q_count;
    logic                   word_accept;
    logic [SW-1:0]          word_skip;
    logic [PW-1:0]          live_pend;
    logic                   pop_en;

    bpq_fetch_ctrl #(
        .AW(AW), .QBYTES(QBYTES), .WBYTES(WBYTES), .MAX_PEND(MAX_PEND),
        .CW(CW), .SW(SW), .PW(PW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .jump_valid(jump_valid), .jump_target(jump_target),
        .mem_valid(mem_valid), .q_count(q_count),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .word_accept(word_accept), .word_skip(word_skip),
        .live_pend(live_pend)
    );

    bpq_byte_store #(
        .QBYTES(QBYTES), .WBYTES(WBYTES), .CW(CW), .SW(SW)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .flush(jump_valid),
        .pop_en(pop_en), .pop_len(CW'(inst_len)),
        .push_en(word_accept), .push_word(mem_data), .push_skip(word_skip),
        .bytes_o(q_bytes), .count_o(q_count)
    );

    bpq_len_decode u_len (
        .opcode(q_bytes[0]),
        .len(inst_len),
        .unknown(inst_unknown)
    );

    // Offer the head instruction once all its bytes are queued; zero unused bytes.
    always_comb begin
        inst_valid = !jump_valid && (int'(q_count) >= int'(inst_len));
        pop_en     = inst_valid && inst_ready;
        for (int k = 0; k < MAX_INSN; k++) begin
            inst_bytes[8*k +: 8] = (k < int'(inst_len)) ? q_bytes[k] : 8'h00;
        end
    end
endmodule

// File: rtl/bytecode_prefetch_queue_chk.sv
// Assertion checker for the prefetch queue, attached to every instance of the
// top through bind. It watches the ports plus the occupancy and live-request
// counts, which come from separate submodules.
module bytecode_prefetch_queue_chk #(
    parameter int AW       = 32,
    parameter int QBYTES   = 8,
    parameter int WBYTES   = 4,
    parameter int MAX_PEND = 2,
    parameter int CW       = 4,
    parameter int PW       = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_req,
    input logic [AW-1:0] fetch_addr,
    input logic          jump_valid,
    input logic [AW-1:0] jump_target,
    input logic          inst_valid,
    input logic          inst_ready,
    input logic [39:0]   inst_bytes,
    input logic [2:0]    inst_len,
    input logic          inst_unknown,
    input logic [CW-1:0] q_count,
    input logic [PW-1:0] live_pend
);
    logic          seen_jump;
    logic          want_first;
    logic [AW-1:0] first_addr;
    logic [AW-1:0] last_addr;

    // Record jumps and the most recent request address for sequence checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_jump  <= 1'b0;
            want_first <= 1'b0;
            first_addr <= '0;
            last_addr  <= '0;
        end else if (jump_valid) begin
            seen_jump  <= 1'b1;
            want_first <= 1'b1;
            first_addr <= {jump_target[AW-1:2], 2'b00};
        end else if (fetch_req) begin
            want_first <= 1'b0;
            last_addr  <= fetch_addr;
        end
    end

    assert_idle_until_jump_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req || inst_valid) |-> seen_jump);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count) <= QBYTES);

    assert_first_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && want_first) |-> (fetch_addr == first_addr));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !want_first && seen_jump) |-> (fetch_addr == last_addr + AW'(WBYTES)));

    assert_live_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(live_pend) <= MAX_PEND);

    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        jump_valid |=> (q_count == '0));

    assert_len_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        inst_valid |-> (inst_len >= 3'd1 && inst_len <= 3'd5));

    assert_unknown_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid && inst_unknown) |-> (inst_len == 3'd1));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inst_valid && !inst_ready) && !jump_valid) |-> (inst_valid && $stable(inst_bytes)));
endmodule

bind bytecode_prefetch_queue bytecode_prefetch_queue_chk #(
    .AW(AW), .QBYTES(QBYTES), .WBYTES(WBYTES), .MAX_PEND(MAX_PEND),
    .CW(CW), .PW(PW)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .jump_valid(jump_valid), .jump_target(jump_target),
    .inst_valid(inst_valid), .inst_ready(inst_ready),
    .inst_bytes(inst_bytes), .inst_len(inst_len), .inst_unknown(inst_unknown),
    .q_count(q_count), .live_pend(live_pend)
);

// File: tb/bytecode_prefetch_queue_tb.sv
// Self-checking bench. It models an in-order memory with random latency and
// tracks the byte stream and the queue occupancy it expects to see.
module bytecode_prefetch_queue_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        mem_valid;
    logic [31:0] mem_data;
    logic        jump_valid;
    logic [31:0] jump_target;
    logic        inst_ready;
    logic        inst_valid;
    logic [39:0] inst_bytes;
    logic [2:0]  inst_len;
    logic        inst_unknown;

    int n_chk = 0;
    int n_fail = 0;
    int issued = 0;

    logic [31:0] faddr [4];
    bit          flive [4];
    int          fcnt = 0;
    int          occ = 0;
    bit          started = 0;
    bit          after_jump = 0;
    int          bskip = 0;
    int          jskip = 0;
    logic [31:0] exp_pc = '0;
    logic [31:0] exp_faddr = '0;
    bit          hold_prev = 0;
    logic [39:0] prev_bytes = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytecode_prefetch_queue u_dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .mem_valid(mem_valid), .mem_data(mem_data),
        .jump_valid(jump_valid), .jump_target(jump_target),
        .inst_ready(inst_ready), .inst_valid(inst_valid),
        .inst_bytes(inst_bytes), .inst_len(inst_len), .inst_unknown(inst_unknown)
    );

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        logic [31:0] h;
        h = a * 32'd2654435761;
        return h[20:13] ^ a[7:0];
    endfunction

    function automatic logic [31:0] mword(input logic [31:0] a);
        return {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)};
    endfunction

    function automatic int ref_len(input logic [7:0] op);
        case (op[7:4])
            4'h0, 4'h1, 4'h2, 4'h3: return 1;
            4'h4, 4'h5:             return 2;
            4'h6, 4'h7:             return 3;
            4'h8:                   return 4;
            4'h9:                   return 5;
            default:                return 1;
        endcase
    endfunction

    function automatic bit ref_unknown(input logic [7:0] op);
        return op[7:4] >= 4'hA;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic observe(input logic [31:0] tgt);
        int live;
        int elen;
        bit exp_valid;
        logic [39:0] eb;
        live = 0;
        for (int i = 0; i < fcnt; i++) live += int'(flive[i]);
        elen = ref_len(mbyte(exp_pc));
        if (hold_prev && !jump_valid) begin
            chk(inst_valid, "R10 instruction held while stalled", 64'(inst_valid), 64'd1);
            chk(inst_bytes == prev_bytes, "R10 bytes stable while stalled", 64'(inst_bytes), 64'(prev_bytes));
        end
        exp_valid = started && !jump_valid && occ > 0 && occ >= elen;
        chk(inst_valid == exp_valid, started ? "R4 valid iff complete" : "R1 idle valid",
            64'(inst_valid), 64'(exp_valid));
        if (inst_valid && inst_ready && exp_valid) begin
            eb = '0;
            for (int k = 0; k < 5; k++) if (k < elen) eb[8*k +: 8] = mbyte(exp_pc + 32'(k));
            chk(inst_bytes == eb,
                after_jump ? (jskip != 0 ? "R9 first bytes at unaligned target" : "R6 first bytes at target")
                           : "R4 instruction bytes",
                64'(inst_bytes), 64'(eb));
            chk(int'(inst_len) == elen, "R7 length", 64'(inst_len), 64'(elen));
            chk(inst_unknown == ref_unknown(mbyte(exp_pc)), "R8 unknown flag",
                64'(inst_unknown), 64'(ref_unknown(mbyte(exp_pc))));
            issued++;
            after_jump = 0;
        end
        if (!started) chk(!fetch_req, "R1 idle fetch", 64'(fetch_req), 64'd0);
        if (fetch_req) begin
            chk(live < 2, "R5 live outstanding", 64'(live), 64'd1);
            chk(occ + 4 * (live + 1) <= 8, "R2 room for word", 64'(occ + 4 * (live + 1)), 64'd8);
            chk(fetch_addr == exp_faddr, "R3 fetch address", 64'(fetch_addr), 64'(exp_faddr));
        end
        if (inst_valid && inst_ready && !jump_valid) begin
            occ -= elen;
            exp_pc += 32'(elen);
        end
        if (mem_valid) begin
            if (flive[0] && !jump_valid) begin
                occ += 4 - bskip;
                bskip = 0;
            end
            for (int i = 0; i < 3; i++) begin
                faddr[i] = faddr[i+1];
                flive[i] = flive[i+1];
            end
            fcnt--;
        end
        if (fetch_req) begin
            faddr[fcnt] = exp_faddr;
            flive[fcnt] = 1'b1;
            fcnt++;
            exp_faddr += 32'd4;
        end
        if (jump_valid) begin
            for (int i = 0; i < 4; i++) flive[i] = 1'b0;
            occ = 0;
            exp_pc = tgt;
            exp_faddr = {tgt[31:2], 2'b00};
            bskip = int'(tgt[1:0]);
            jskip = bskip;
            started = 1;
            after_jump = 1;
        end
        hold_prev = inst_valid && !inst_ready && !jump_valid;
        prev_bytes = inst_bytes;
    endtask

    task automatic cycle(input bit jmp, input logic [31:0] tgt, input bit rdy, input int mem_pct);
        @(negedge clk);
        jump_valid = jmp;
        jump_target = tgt;
        inst_ready = rdy;
        if (fcnt > 0 && int'($urandom_range(99)) < mem_pct) begin
            mem_valid = 1'b1;
            mem_data = mword(faddr[0]);
        end else begin
            mem_valid = 1'b0;
            mem_data = '0;
        end
        #1;
        observe(tgt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R4 actual=hung expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        mem_valid = 1'b0;
        mem_data = '0;
        jump_valid = 1'b0;
        jump_target = '0;
        inst_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk(!fetch_req && !inst_valid, "R1 reset outputs", 64'({fetch_req, inst_valid}), 64'd0);
        rst_n = 1'b1;
        repeat (5) cycle(1'b0, 32'h0, 1'b1, 50);
        // Aligned start and steady streaming.
        cycle(1'b1, 32'h200, 1'b1, 50);
        repeat (40) cycle(1'b0, 32'h0, 1'b1, 70);
        // Unaligned targets, one per offset.
        cycle(1'b1, 32'h301, 1'b1, 50);
        repeat (30) cycle(1'b0, 32'h0, 1'b1, 70);
        cycle(1'b1, 32'h402, 1'b1, 50);
        repeat (30) cycle(1'b0, 32'h0, 1'b1, 70);
        cycle(1'b1, 32'h503, 1'b1, 50);
        repeat (30) cycle(1'b0, 32'h0, 1'b1, 70);
        // Long decode stall fills the queue, then drains.
        cycle(1'b1, 32'h600, 1'b0, 50);
        repeat (25) cycle(1'b0, 32'h0, 1'b0, 80);
        repeat (20) cycle(1'b0, 32'h0, 1'b1, 80);
        // Jumps while words are still outstanding leave stale responses.
        repeat (3) cycle(1'b0, 32'h0, 1'b1, 0);
        cycle(1'b1, 32'h700, 1'b1, 0);
        cycle(1'b0, 32'h0, 1'b1, 0);
        cycle(1'b1, 32'h7A3, 1'b1, 100);
        repeat (30) cycle(1'b0, 32'h0, 1'b1, 100);
        // Random mix of jumps, stalls and memory latency.
        for (int n = 0; n < 20000; n++) begin
            cycle($urandom_range(39) == 0, 32'h1000 + 32'($urandom_range(4095)),
                  $urandom_range(3) != 0, 60);
        end
        chk(issued > 2000, "R4 forward progress", 64'(issued), 64'd2000);
        summary();
        $finish;
    end
endmodule